// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block decides which of four DMA channels is served next. Each channel can ask for service in two ways: a hardware request line, which a per-channel mask bit can block, and a software request bit, which the host sets. The mask does not block the software request. In one mode the winner comes from a fixed order. In the other mode the order rotates so that no channel can hold the bus for long.

The transfer sequencer gives the block an idle indication and one pulse when a service ends. The pulse says how the service ended: a plain finish, a terminal count, or an external end-of-process. A terminal count or an end-of-process updates the channel's sticky completion flag, its software request and its mask. The host uses a small register port to set or clear single request and mask bits, to select the priority mode, to issue master-clear and unmask-all commands, and to read a status byte.

Host map, with `hostAddr`, `hostWData` and `hostRData`:
- Address 0: a write sets the mode. A read returns the status byte.
- Address 1: a write changes one software request bit. A read returns the software request bits.
- Address 2: a write changes one mask bit. A read returns the mask bits.
- Address 3: a write issues a command. A read returns the mode bit.

Top module: `dma_req_arbiter`

## Requirements
- R1: Reset and master clear leave the block in the same state:
  - Master clear is a write to address 3 with `hostWData[0]`=1.
  - No grant is held.
  - All four mask bits are 1.
  - All software request bits, completion flags and the rotating-mode bit are 0.
  - Channel 0 is the first channel in the search order.
- R2: A channel's effective request is (hardware request AND NOT mask) OR software request. In fixed mode (mode bit 0), the lowest-numbered effective channel wins.
- R3: The mode bit is `hostWData[0]` of a write to address 0. In rotating mode (mode bit 1), the search starts at the channel after the most recently granted channel. A channel that stays pending is therefore granted after no more than three grants to other channels.
- R4: Grant timing:
  - A grant is taken only when `grantValid` is low and `seqIdle` is high.
  - `grantValid` and `grantChan` change at the next clock edge.
  - `grantChan` stays stable until `seqDone`, `seqTc` or `seqExtEop` ends the service.
  - These end pulses have no effect while no grant is held.
- R5: Host access to single bits:
  - A write to address 1 sets (`hostWData[2]`=1) or clears (`hostWData[2]`=0) the software request bit of the channel given by `hostWData[1:0]`.
  - A write to address 2 does the same for that channel's mask bit.
  - Reads of addresses 1, 2 and 3 return the request bits, the mask bits and the mode bit, each in the low bits with zeros above.
- R6: When a service ends through `seqTc` or `seqExtEop`, the block does three things for the granted channel:
  - it sets the completion flag;
  - it clears the software request bit;
  - it sets the mask bit, unless `autoInit` is high for that channel.
  An end through `seqDone` changes none of these bits.
- R7: Status byte:
  - Bits 3:0 are the sticky completion flags.
  - Bits 7:4 are the raw pending requests (hardware line OR software bit, with the mask not applied).
  - A read of address 0 clears the completion flags at the clock edge.
  - A flag that an end pulse sets in the same cycle as the read stays set.
- R8: A write to address 3 with `hostWData[0]`=0 and `hostWData[1]`=1 clears all four mask bits. A host request or mask write takes priority over an end-pulse update to the same bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hwReq | input | 4 | Hardware request line per channel |
| autoInit | input | 4 | Per channel: the channel re-arms itself, so its mask is not set when it completes |
| seqIdle | input | 1 | Sequencer is free to start a new service |
| seqDone | input | 1 | Service ended without terminal count |
| seqTc | input | 1 | Service ended at terminal count |
| seqExtEop | input | 1 | Service ended by external end-of-process |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe (clears flags on address 0) |
| hostAddr | input | 2 | Host register address |
| hostWData | input | 8 | Host write data |
| hostRData | output | 8 | Host read data, combinational from current state |
| grantValid | output | 1 | A channel holds the grant |
| grantChan | output | 2 | Granted channel number |

## Verification
Faults in the internal state show up at the ports soon after they occur:
- A wrong rotation pointer gives a wrong `grantChan` on the next grant after the pointer moves.
- A lost or extra mask or request bit changes `hostRData` at addresses 1 and 2 in the same cycle. It also changes which channel wins in the cycle that follows.
- A completion flag that is cleared too early, or never cleared, shows up on the next status read.

A reference model in the bench is compared with every output on every cycle, so a divergence is reported within one clock of the edge that caused it.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int CH_N = 4;

  // One-cycle strobes from control to datapath
  typedef struct packed {
    logic setReq;
    logic clrReq;
    logic setMask;
    logic clrMask;
    logic clrAllMask;
    logic masterClr;
    logic wrCmd;
    logic cmdRot;
    logic rdStatus;
    logic takeGrant;
    logic endAny;
    logic endTerm;
  } arbStrobe_t;
endpackage

// File: rtl/dma_arb_ctrl.sv
module dma_arb_ctrl
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = CH_N,
  parameter int ADDR_W = 2,
  localparam int DW = 2 * NUM_CH,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DW-1:0]     hostWData,
  input  logic              seqIdle,
  input  logic              seqDone,
  input  logic              seqTc,
  input  logic              seqExtEop,
  input  logic              anyReq,
  input  logic [CH_W-1:0]   winner,
  output arbStrobe_t        strb,
  output logic [CH_W-1:0]   hostChan,
  output logic              grantValid,
  output logic [CH_W-1:0]   grantChan
);
  logic gvQ;
  logic [CH_W-1:0] gcQ;

  assign hostChan = hostWData[CH_W-1:0];
  assign grantValid = gvQ;
  assign grantChan = gcQ;

  always_comb begin
    strb = '0;
    strb.cmdRot = hostWData[0];
    if (hostWr) begin
      case (hostAddr)
        ADDR_W'(0): strb.wrCmd = 1'b1;
        ADDR_W'(1): begin
          strb.setReq = hostWData[2];
          strb.clrReq = ~hostWData[2];
        end
        ADDR_W'(2): begin
          strb.setMask = hostWData[2];
          strb.clrMask = ~hostWData[2];
        end
        default: begin
          strb.masterClr = hostWData[0];
          strb.clrAllMask = ~hostWData[0] & hostWData[1];
        end
      endcase
    end
    strb.rdStatus = hostRd & ~hostWr & (hostAddr == ADDR_W'(0));
    strb.endAny = gvQ & (seqDone | seqTc | seqExtEop);
    strb.endTerm = gvQ & (seqTc | seqExtEop);
    strb.takeGrant = ~gvQ & seqIdle & anyReq & ~strb.masterClr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gvQ <= 1'b0;
      gcQ <= '0;
    end else if (strb.masterClr || strb.endAny) begin
      gvQ <= 1'b0;
    end else if (strb.takeGrant) begin
      gvQ <= 1'b1;
      gcQ <= winner;
    end
  end

  // R4: grant held steady until an end pulse
  p_grant_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (gvQ && !(seqDone || seqTc || seqExtEop) && !strb.masterClr)
      |=> (gvQ && $stable(gcQ)));

  // R4: a grant only starts from an idle sequencer
  p_grant_idle_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(gvQ) |-> $past(seqIdle));
endmodule

// File: rtl/dma_arb_dp.sv
module dma_arb_dp
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = CH_N,
  parameter int ADDR_W = 2,
  localparam int DW = 2 * NUM_CH,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  arbStrobe_t        strb,
  input  logic [CH_W-1:0]   hostChan,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [NUM_CH-1:0] hwReq,
  input  logic [NUM_CH-1:0] autoInit,
  input  logic [CH_W-1:0]   grantChan,
  output logic              anyReq,
  output logic [CH_W-1:0]   winner,
  output logic [DW-1:0]     hostRData
);
  logic [NUM_CH-1:0] maskQ, sreqQ, tcQ;
  logic [NUM_CH-1:0] maskNext, sreqNext, tcNext;
  logic              rotQ;
  logic [CH_W-1:0]   lastQ;
  logic [NUM_CH-1:0] effReq, rawPend;
  logic [CH_W-1:0]   startIdx, idx;
  logic              found;

  assign effReq = (hwReq & ~maskQ) | sreqQ;
  assign rawPend = hwReq | sreqQ;
  assign anyReq = |effReq;
  assign startIdx = rotQ ? lastQ + CH_W'(1) : '0;

  // Search starting at startIdx, wrapping around
  always_comb begin
    winner = '0;
    found = 1'b0;
    idx = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      idx = startIdx + CH_W'(k);
      if (!found && effReq[idx]) begin
        winner = idx;
        found = 1'b1;
      end
    end
  end

  always_comb begin
    tcNext = tcQ;
    sreqNext = sreqQ;
    maskNext = maskQ;
    if (strb.rdStatus) tcNext = '0;
    if (strb.endTerm) begin
      tcNext[grantChan] = 1'b1;
      sreqNext[grantChan] = 1'b0;
      if (!autoInit[grantChan]) maskNext[grantChan] = 1'b1;
    end
    if (strb.setReq) sreqNext[hostChan] = 1'b1;
    if (strb.clrReq) sreqNext[hostChan] = 1'b0;
    if (strb.clrAllMask) maskNext = '0;
    if (strb.setMask) maskNext[hostChan] = 1'b1;
    if (strb.clrMask) maskNext[hostChan] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || strb.masterClr) begin
      maskQ <= '1;
      sreqQ <= '0;
      tcQ <= '0;
      rotQ <= 1'b0;
      lastQ <= CH_W'(NUM_CH - 1);
    end else begin
      maskQ <= maskNext;
      sreqQ <= sreqNext;
      tcQ <= tcNext;
      if (strb.wrCmd) rotQ <= strb.cmdRot;
      if (strb.takeGrant) lastQ <= winner;
    end
  end

  always_comb begin
    case (hostAddr)
      ADDR_W'(0): hostRData = {rawPend, tcQ};
      ADDR_W'(1): hostRData = {{NUM_CH{1'b0}}, sreqQ};
      ADDR_W'(2): hostRData = {{NUM_CH{1'b0}}, maskQ};
      default:    hostRData = {{(DW-1){1'b0}}, rotQ};
    endcase
  end

  // R2: in fixed mode a pending channel 0 always wins
  p_fixed_top_r2: assert property (@(posedge clk) disable iff (rst)
    (strb.takeGrant && !rotQ && effReq[0]) |-> (winner == '0));

  // R6: a terminal end masks a non-re-arming channel
  p_eop_mask_r6: assert property (@(posedge clk) disable iff (rst)
    (strb.endTerm && !autoInit[grantChan] && !strb.clrMask && !strb.clrAllMask
      && !strb.masterClr) |=> maskQ[$past(grantChan)]);

  // R1: master clear restores the reset state
  p_mclr_state_r1: assert property (@(posedge clk) disable iff (rst)
    strb.masterClr |=> (maskQ == '1 && sreqQ == '0 && tcQ == '0 && !rotQ));

  // R3: per channel, count grants to others while it waits in rotating mode
  for (genvar c = 0; c < NUM_CH; c++) begin : g_fair
    logic [CH_W:0] waitCnt;
    always_ff @(posedge clk) begin
      if (rst || !rotQ || !effReq[c] || (strb.takeGrant && winner == CH_W'(c)))
        waitCnt <= '0;
      else if (strb.takeGrant)
        waitCnt <= waitCnt + 1'b1;
    end
    p_rot_bound_r3: assert property (@(posedge clk) disable iff (rst)
      (rotQ && strb.takeGrant && effReq[c] && winner != CH_W'(c))
        |-> (int'(waitCnt) < NUM_CH - 1));
  end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = CH_N,
  parameter int ADDR_W = 2,
  localparam int DW = 2 * NUM_CH,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] hwReq,
  input  logic [NUM_CH-1:0] autoInit,
  input  logic              seqIdle,
  input  logic              seqDone,
  input  logic              seqTc,
  input  logic              seqExtEop,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DW-1:0]     hostWData,
  output logic [DW-1:0]     hostRData,
  output logic              grantValid,
  output logic [CH_W-1:0]   grantChan
);
  arbStrobe_t strb;
  logic [CH_W-1:0] hostChan, winner;
  logic anyReq;

  dma_arb_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .hostWr(hostWr), .hostRd(hostRd),
    .hostAddr(hostAddr), .hostWData(hostWData), .seqIdle(seqIdle),
    .seqDone(seqDone), .seqTc(seqTc), .seqExtEop(seqExtEop),
    .anyReq(anyReq), .winner(winner), .strb(strb), .hostChan(hostChan),
    .grantValid(grantValid), .grantChan(grantChan)
  );

  dma_arb_dp #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .hostChan(hostChan),
    .hostAddr(hostAddr), .hwReq(hwReq), .autoInit(autoInit),
    .grantChan(grantChan), .anyReq(anyReq), .winner(winner),
    .hostRData(hostRData)
  );
endmodule

// File: tb/sim_dma_req_arbiter.sv
`timescale 1ns/1ps
module sim_dma_req_arbiter;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic [3:0] hwReq = '0, autoInit = '0;
  logic seqIdle = 1'b1, seqDone = 1'b0, seqTc = 1'b0, seqExtEop = 1'b0;
  logic hostWr = 1'b0, hostRd = 1'b0;
  logic [1:0] hostAddr = '0;
  logic [7:0] hostWData = '0;
  logic [7:0] hostRData;
  logic grantValid;
  logic [1:0] grantChan;

  dma_req_arbiter u0 (
    .clk(clk), .rst(rst), .hwReq(hwReq), .autoInit(autoInit),
    .seqIdle(seqIdle), .seqDone(seqDone), .seqTc(seqTc), .seqExtEop(seqExtEop),
    .hostWr(hostWr), .hostRd(hostRd), .hostAddr(hostAddr),
    .hostWData(hostWData), .hostRData(hostRData),
    .grantValid(grantValid), .grantChan(grantChan)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model state
  logic [3:0] mMask = 4'hF, mSreq = '0, mTc = '0;
  logic mRot = 1'b0, mGv = 1'b0;
  logic [1:0] mLast = 2'd3, mGc = '0;

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [1:0] pickWin(input logic [3:0] eff, input logic rot,
                                         input logic [1:0] last);
    logic [1:0] s = rot ? last + 2'd1 : 2'd0;
    for (int k = 0; k < 4; k++) begin
      logic [1:0] i = s + 2'(k);
      if (eff[i]) return i;
    end
    return 2'd0;
  endfunction

  function automatic logic [7:0] expRd();
    case (hostAddr)
      2'd0: return {hwReq | mSreq, mTc};
      2'd1: return {4'h0, mSreq};
      2'd2: return {4'h0, mMask};
      default: return {7'h0, mRot};
    endcase
  endfunction

  task automatic modelReset();
    mMask = 4'hF; mSreq = '0; mTc = '0; mRot = 1'b0; mGv = 1'b0; mLast = 2'd3;
  endtask

  task automatic modelUpdate();
    logic [3:0] eff;
    logic [1:0] w;
    if (rst) begin modelReset(); return; end
    eff = (hwReq & ~mMask) | mSreq;
    if (hostRd && !hostWr && hostAddr == 2'd0) mTc = '0;
    if (mGv) begin
      if (seqDone || seqTc || seqExtEop) begin
        if (seqTc || seqExtEop) begin
          mTc[mGc] = 1'b1;
          mSreq[mGc] = 1'b0;
          if (!autoInit[mGc]) mMask[mGc] = 1'b1;
        end
        mGv = 1'b0;
      end
    end else if (seqIdle && eff != 0) begin
      w = pickWin(eff, mRot, mLast);
      mGv = 1'b1; mGc = w; mLast = w;
    end
    if (hostWr) begin
      case (hostAddr)
        2'd0: mRot = hostWData[0];
        2'd1: mSreq[hostWData[1:0]] = hostWData[2];
        2'd2: mMask[hostWData[1:0]] = hostWData[2];
        default: if (hostWData[0]) modelReset();
                 else if (hostWData[1]) mMask = '0;
      endcase
    end
  endtask

  task automatic compare();
    chk("R4 grantValid", int'(grantValid), int'(mGv));
    if (mGv) chk(mRot ? "R3 grantChan" : "R2 grantChan", int'(grantChan), int'(mGc));
    chk(hostAddr == 2'd0 ? "R7 status" : "R5 readback", int'(hostRData), int'(expRd()));
  endtask

  task automatic step();
    #1;
    if (!rst) compare();
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [7:0] d);
    hostWr = 1'b1; hostAddr = a; hostWData = d;
    step();
    hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] a, output logic [7:0] d);
    hostRd = 1'b1; hostAddr = a;
    #1 d = hostRData;
    step();
    hostRd = 1'b0;
  endtask

  task automatic endWith(input int kind);
    seqDone = (kind == 0); seqTc = (kind == 1); seqExtEop = (kind == 2);
    step();
    seqDone = 1'b0; seqTc = 1'b0; seqExtEop = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'd4711));
    @(negedge clk);
    step(); step();
    rst = 1'b0;
    step();
    // R1 reset state
    chk("R1 no grant", int'(grantValid), 0);
    hostRead(2'd2, rd); chk("R1 masks set", int'(rd), 8'h0F);
    hostRead(2'd3, rd); chk("R1 fixed mode", int'(rd), 0);

    // R2 all masked: no grant
    hwReq = 4'hF; step(); step();
    chk("R2 masked no grant", int'(grantValid), 0);
    // R8 clear all masks
    hostWrite(2'd3, 8'h02);
    step();
    chk("R8 unmasked grant", int'(grantValid), 1);
    chk("R2 fixed winner", int'(grantChan), 0);
    // R4 hold under changing requests
    hwReq = 4'b0010; step(); step();
    chk("R4 held", int'(grantChan), 0);
    endWith(0);
    chk("R4 released", int'(grantValid), 0);
    step();
    chk("R2 next winner", int'(grantChan), 1);
    hostRead(2'd2, rd); chk("R6 plain end keeps mask", int'(rd), 0);
    endWith(1);
    hostRead(2'd2, rd); chk("R6 tc masks channel", int'(rd), 8'h02);
    hostRead(2'd0, rd); chk("R7 status flags", int'(rd), 8'h22);
    hostRead(2'd0, rd); chk("R7 read clears", int'(rd), 8'h20);

    // R6 auto-initialize keeps mask clear
    autoInit = 4'b0001; hwReq = 4'b0001; step();
    chk("R6 grant ch0", int'(grantChan), 0);
    endWith(2);
    hostRead(2'd2, rd); chk("R6 autoinit mask", int'(rd), 8'h02);
    hwReq = 4'h0;
    if (grantValid) endWith(0);

    // R5 software request beats mask
    hostWrite(2'd2, 8'h07);
    hostWrite(2'd1, 8'h07);
    step();
    chk("R5 soft grant valid", int'(grantValid), 1);
    chk("R5 soft grant ch3", int'(grantChan), 3);
    hostRead(2'd1, rd); chk("R5 request readback", int'(rd), 8'h08);
    endWith(1);
    hostRead(2'd1, rd); chk("R6 tc clears request", int'(rd), 0);

    // R3 rotating order
    hostWrite(2'd0, 8'h01);
    hostWrite(2'd3, 8'h02);
    hwReq = 4'hF; step();
    for (int k = 0; k < 5; k++) begin
      chk("R3 rotation", int'(grantChan), k % 4);
      if (k < 4) begin endWith(0); step(); end
    end
    // R7 flag set in the same cycle as a clearing read survives
    seqTc = 1'b1; hostRd = 1'b1; hostAddr = 2'd0;
    step();
    seqTc = 1'b0; hostRd = 1'b0;
    hostRead(2'd0, rd); chk("R7 same-cycle flag kept", int'(rd & 8'h0F), 1);
    // R4 busy sequencer blocks a new grant
    if (grantValid) endWith(0);
    seqIdle = 1'b0; step(); step();
    chk("R4 busy no grant", int'(grantValid), 0);
    seqIdle = 1'b1;
    // R1 master clear
    hostWrite(2'd3, 8'h01);
    chk("R1 mclr no grant", int'(grantValid), 0);
    hostRead(2'd2, rd); chk("R1 mclr masks", int'(rd), 8'h0F);
    hostRead(2'd3, rd); chk("R1 mclr mode", int'(rd), 0);

    // random phase against the model
    for (int n = 0; n < 4000; n++) begin
      int r;
      hwReq = 4'($urandom);
      seqIdle = ($urandom % 4) != 0;
      if (n % 64 == 0) autoInit = 4'($urandom);
      seqDone = 1'b0; seqTc = 1'b0; seqExtEop = 1'b0;
      if (mGv) begin
        r = $urandom % 8;
        seqDone = (r == 0); seqTc = (r == 1); seqExtEop = (r == 2);
      end
      hostWr = 1'b0; hostRd = 1'b0;
      r = $urandom % 16;
      hostAddr = 2'($urandom);
      hostWData = 8'($urandom);
      if (r < 3) begin
        hostWr = 1'b1;
        if (hostAddr == 2'd3)
          hostWData = (($urandom % 8) == 0) ? 8'h01 : 8'h02;
      end else if (r < 6) begin
        hostRd = 1'b1;
      end
      step();
    end
    hostWr = 1'b0; hostRd = 1'b0;
    seqDone = 1'b0; seqTc = 1'b0; seqExtEop = 1'b0;

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule